// File: doc/BRIEF.md
# Configuration Load Controller with CRC Retry

This block copies a set of configuration words from a non-volatile memory into shadow registers. It checks the words with a CRC-8 and, when the check fails, repeats the whole load a bounded number of times. A sequence is started by a single-cycle pulse that the surrounding mode logic raises when the device comes out of its sleep or fail-safe state. Requests that arrive while a sequence is running have no effect.

Reads go out over a simple synchronous port, one address per cycle, and the data returns a fixed number of cycles later. Each returned data word is written at once to the shadow register of the same index. The word that follows the data words holds the expected CRC. An attempt that passes sets a configuration-valid flag and ends the sequence. If every permitted attempt fails, three fault flags are raised together: a global one, a category one and a specific one.

Top module: `nvload_ctrl`

## Requirements
- R1: During and right after reset, every output is 0.
- R2: A start pulse seen while idle raises busy_o in the next cycle. From that cycle on, mem_rd_o is high for NUM_WORDS+1 consecutive cycles, with mem_addr_o stepping 0, 1, ... NUM_WORDS, one address per cycle.
- R3: Data for a read issued in cycle c is taken from mem_data_i in cycle c+RD_LAT. For addresses below NUM_WORDS, shd_we_o pulses in that same cycle with shd_addr_o equal to the address and shd_data_o equal to the data. This happens on every attempt.
- R4: The check is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0xFF. It is computed MSB first, with no reflection and no final XOR, over data words 0..NUM_WORDS-1 in address order. Word NUM_WORDS must equal that CRC in its low 8 bits, with all higher bits zero.
- R5: A passing attempt ends the sequence. In the next cycle busy_o is 0, done_o pulses for one cycle, cfg_valid_o is 1 and all fault flags are 0.
- R6: A failing attempt that is not the last starts a new attempt in the next cycle. The new attempt reads again from address 0 with a fresh CRC. At most MAX_TRIES (8) attempts are made per sequence, and each attempt lasts NUM_WORDS+1+RD_LAT cycles.
- R7: If all MAX_TRIES attempts fail, then in the next cycle flt_global_o, flt_group_o and flt_crc_o are 1, cfg_valid_o is 0, busy_o is 0 and done_o pulses.
- R8: A start pulse while busy_o is 1 changes neither the number of attempts nor the length of the sequence.
- R9: Accepting a start clears cfg_valid_o and all fault flags in the first busy cycle.
- R10: A sequence is busy for at most WORST_CYCLES = MAX_TRIES*(NUM_WORDS+1+RD_LAT) cycles, and a sequence in which every attempt fails takes exactly that long.
- R11: A pass clears the attempt count, so the next sequence again gets the full MAX_TRIES attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse on exit from sleep or fail-safe state |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_data_i | input | DATA_W | Memory read data, RD_LAT cycles after request |
| shd_we_o | output | 1 | Shadow register write strobe |
| shd_addr_o | output | SHD_AW | Shadow register index |
| shd_data_o | output | DATA_W | Shadow register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| cfg_valid_o | output | 1 | Last sequence passed its CRC check |
| flt_global_o | output | 1 | Global interrupt flag: all attempts failed |
| flt_group_o | output | 1 | Fault category flag: all attempts failed |
| flt_crc_o | output | 1 | Specific CRC fault flag: all attempts failed |

## Verification
A wrong attempt counter shows up at the memory port within one attempt (NUM_WORDS+1+RD_LAT cycles). It appears there as a missing or extra burst that starts at address 0, or as a sequence that runs too short or too long. A bad CRC register or a bad compare turns pass into fail, or fail into pass, one cycle after the CRC word returns. That shows as an unexpected retry burst, or as wrong valid and fault flags next to done_o. A bench model that tracks each cycle's expected read address, shadow write and flags catches any such fault in the cycle where it first reaches a port.

// File: rtl/nvload_pkg.sv
package nvload_pkg;

    localparam int         CRC_W    = 8;
    localparam logic [7:0] CRC_POLY = 8'h07;
    localparam logic [7:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/nvload_crc8.sv
module nvload_crc8
    import nvload_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 upd_i,
    input  logic [DATA_W-1:0]    data_i,
    output logic [CRC_W-1:0]     crc_o
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_reg_t;

    crc_reg_t state_d, state_q;
    logic [CRC_W-1:0] folded;

    // Serial MSB-first division, unrolled over one data word
    always_comb begin
        folded = state_q.crc;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (folded[CRC_W-1] ^ data_i[i]) begin
                folded = {folded[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            end else begin
                folded = {folded[CRC_W-2:0], 1'b0};
            end
        end
        state_d = state_q;
        if (clr_i) begin
            state_d.crc = CRC_SEED;
        end else if (upd_i) begin
            state_d.crc = folded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{crc: CRC_SEED};
        end else begin
            state_q <= state_d;
        end
    end

    assign crc_o = state_q.crc;

endmodule

// File: rtl/nvload_rdtrack.sv
module nvload_rdtrack #(
    parameter int IDX_W  = 4,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             ret_vld_o,
    output logic [IDX_W-1:0] ret_idx_o
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } slot_t;

    slot_t [RD_LAT-1:0] pipe_d, pipe_q;

    // Each stage follows the read data through the memory latency
    assign pipe_d[0] = {issue_i, idx_i};

    generate
        for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
            assign pipe_d[s] = pipe_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign ret_vld_o = pipe_q[RD_LAT-1].vld;
    assign ret_idx_o = pipe_q[RD_LAT-1].idx;

endmodule

// File: rtl/nvload_seq.sv
module nvload_seq
    import nvload_pkg::*;
#(
    parameter int NUM_WORDS    = 8,
    parameter int DATA_W       = 8,
    parameter int MAX_TRIES    = 8,
    parameter int ADDR_W       = 4,
    parameter int WORST_CYCLES = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ret_vld_i,
    input  logic [ADDR_W-1:0] ret_idx_i,
    input  logic [DATA_W-1:0] ret_data_i,
    input  logic [CRC_W-1:0]  crc_i,
    output logic              issue_o,
    output logic [ADDR_W-1:0] issue_idx_o,
    output logic              crc_clr_o,
    output logic              crc_upd_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              flt_o
);

    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam int CYC_W = $clog2(WORST_CYCLES + 1);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS);
    localparam logic [TRY_W-1:0]  LAST_TRY = TRY_W'(MAX_TRIES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] issue;
        logic [TRY_W-1:0]  tries;
        logic              done;
        logic              valid;
        logic              flt;
        logic [CYC_W-1:0]  cyc;
    } seq_reg_t;

    seq_reg_t q, d;
    logic     ret_data_word;
    logic     ret_crc_word;
    logic     crc_match;

    always_comb begin
        ret_data_word = ret_vld_i && (ret_idx_i < LAST_IDX);
        ret_crc_word  = ret_vld_i && (ret_idx_i == LAST_IDX);
        crc_match     = (ret_data_i[CRC_W-1:0] == crc_i) && ((ret_data_i >> CRC_W) == '0);

        d         = q;
        d.done    = 1'b0;
        crc_clr_o = 1'b0;
        crc_upd_o = ret_data_word;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_FETCH;
                    d.issue   = '0;
                    d.tries   = '0;
                    d.valid   = 1'b0;
                    d.flt     = 1'b0;
                    d.cyc     = '0;
                    crc_clr_o = 1'b1;
                end
            end
            ST_FETCH: begin
                d.cyc = q.cyc + CYC_W'(1);
                if (q.issue == LAST_IDX) begin
                    d.st = ST_WAIT;
                end else begin
                    d.issue = q.issue + ADDR_W'(1);
                end
            end
            ST_WAIT: begin
                d.cyc = q.cyc + CYC_W'(1);
                if (ret_crc_word) begin
                    if (crc_match) begin
                        d.st    = ST_IDLE;
                        d.valid = 1'b1;
                        d.done  = 1'b1;
                        d.tries = '0;
                    end else if (q.tries == LAST_TRY) begin
                        d.st    = ST_IDLE;
                        d.flt   = 1'b1;
                        d.done  = 1'b1;
                        d.tries = '0;
                    end else begin
                        d.st      = ST_FETCH;
                        d.issue   = '0;
                        d.tries   = q.tries + TRY_W'(1);
                        crc_clr_o = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, issue: '0, tries: '0, done: 1'b0,
                   valid: 1'b0, flt: 1'b0, cyc: '0};
        end else begin
            q <= d;
        end
    end

    assign issue_o     = (q.st == ST_FETCH);
    assign issue_idx_o = q.issue;
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign valid_o     = q.valid;
    assign flt_o       = q.flt;

    // Attempt counter never reaches the limit while a sequence runs
    assert_tries_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries < TRY_W'(MAX_TRIES));

    // Every attempt starts from the CRC seed value
    assert_fresh_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && q.issue == '0) |-> (crc_i == CRC_SEED));

    // The busy window stays within the worst-case cycle budget
    assert_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.cyc < CYC_W'(WORST_CYCLES)));

    // A start during a burst does not restart the address sequence
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && q.issue != '0 && start_i) |=> (q.issue != '0));

    // A pass ends with done and no fault
    assert_pass_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> (q.done && !q.flt));

endmodule

// File: rtl/nvload_ctrl.sv
module nvload_ctrl
    import nvload_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int NUM_WORDS    = 8,
    parameter int RD_LAT       = 2,
    parameter int MAX_TRIES    = 8,
    parameter int WORST_CYCLES = MAX_TRIES * (NUM_WORDS + 1 + RD_LAT),
    parameter int ADDR_W       = $clog2(NUM_WORDS + 1),
    parameter int SHD_AW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              shd_we_o,
    output logic [SHD_AW-1:0] shd_addr_o,
    output logic [DATA_W-1:0] shd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cfg_valid_o,
    output logic              flt_global_o,
    output logic              flt_group_o,
    output logic              flt_crc_o
);

    logic              ret_vld;
    logic [ADDR_W-1:0] ret_idx;
    logic              crc_clr;
    logic              crc_upd;
    logic [CRC_W-1:0]  crc_val;
    logic              flt;

    nvload_rdtrack #(
        .IDX_W  (ADDR_W),
        .RD_LAT (RD_LAT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (mem_rd_o),
        .idx_i     (mem_addr_o),
        .ret_vld_o (ret_vld),
        .ret_idx_o (ret_idx)
    );

    nvload_crc8 #(
        .DATA_W (DATA_W)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .upd_i  (crc_upd),
        .data_i (mem_data_i),
        .crc_o  (crc_val)
    );

    nvload_seq #(
        .NUM_WORDS    (NUM_WORDS),
        .DATA_W       (DATA_W),
        .MAX_TRIES    (MAX_TRIES),
        .ADDR_W       (ADDR_W),
        .WORST_CYCLES (WORST_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ret_vld_i   (ret_vld),
        .ret_idx_i   (ret_idx),
        .ret_data_i  (mem_data_i),
        .crc_i       (crc_val),
        .issue_o     (mem_rd_o),
        .issue_idx_o (mem_addr_o),
        .crc_clr_o   (crc_clr),
        .crc_upd_o   (crc_upd),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .valid_o     (cfg_valid_o),
        .flt_o       (flt)
    );

    // Data words go straight into the shadow registers as they return
    assign shd_we_o     = crc_upd;
    assign shd_addr_o   = ret_idx[SHD_AW-1:0];
    assign shd_data_o   = mem_data_i;

    assign flt_global_o = flt;
    assign flt_group_o  = flt;
    assign flt_crc_o    = flt;

    // Shadow writes happen only inside a sequence
    assert_shd_in_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shd_we_o |-> busy_o);

    // Read addresses stay within data words plus the CRC word
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o <= ADDR_W'(NUM_WORDS)));

    // All three fault flags rise together, with valid clear
    assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_crc_o) |-> (flt_global_o && flt_group_o && !cfg_valid_o && done_o));

endmodule

// File: tb/nvload_ctrl_bench.sv
module nvload_ctrl_bench;

    localparam int DW    = 8;
    localparam int N     = 8;
    localparam int LAT   = 2;
    localparam int MAXT  = 8;
    localparam int L     = N + 1 + LAT;
    localparam int WORST = MAXT * L;
    localparam int AW    = $clog2(N + 1);
    localparam int SAW   = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           mem_rd_o;
    logic [AW-1:0]  mem_addr_o;
    logic [DW-1:0]  mem_data_i;
    logic           shd_we_o;
    logic [SAW-1:0] shd_addr_o;
    logic [DW-1:0]  shd_data_o;
    logic           busy_o, done_o, cfg_valid_o;
    logic           flt_global_o, flt_group_o, flt_crc_o;

    always #10 clk = ~clk;

    nvload_ctrl #(
        .DATA_W (DW), .NUM_WORDS (N), .RD_LAT (LAT), .MAX_TRIES (MAXT)
    ) u_nvload_ctrl (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .mem_rd_o (mem_rd_o), .mem_addr_o (mem_addr_o), .mem_data_i (mem_data_i),
        .shd_we_o (shd_we_o), .shd_addr_o (shd_addr_o), .shd_data_o (shd_data_o),
        .busy_o (busy_o), .done_o (done_o), .cfg_valid_o (cfg_valid_o),
        .flt_global_o (flt_global_o), .flt_group_o (flt_group_o), .flt_crc_o (flt_crc_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory contents and CRC reference
    logic [7:0] mem_arr [0:N];
    int bad_left = 0;
    bit good_q[$];

    function automatic logic [7:0] ref_crc();
        int acc = 255;
        for (int w = 0; w < N; w++) begin
            acc = acc ^ int'(mem_arr[w]);
            for (int b = 0; b < 8; b++) begin
                if ((acc & 128) != 0) acc = ((acc << 1) ^ 7) & 255;
                else acc = (acc << 1) & 255;
            end
        end
        return acc[7:0];
    endfunction

    // Synchronous memory with fixed latency; CRC word can be corrupted
    logic [7:0] pd [LAT];
    always @(posedge clk) begin
        logic [7:0] val;
        val = 8'h00;
        if (rst_n && mem_rd_o) begin
            val = mem_arr[int'(mem_addr_o)];
            if (int'(mem_addr_o) == N) begin
                if (bad_left > 0) begin
                    val = ~val;
                    bad_left--;
                end
                good_q.push_back(val == ref_crc());
            end
        end
        for (int s = LAT - 1; s > 0; s--) pd[s] <= pd[s-1];
        pd[0] <= val;
    end
    assign mem_data_i = pd[LAT-1];

    // Behavioural reference: position inside the current attempt
    bit m_busy, m_done, m_valid, m_flt;
    int m_c, m_a;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_valid = 0; m_flt = 0; m_c = 0; m_a = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_c == L - 1) begin
                    bit ok;
                    ok = (good_q.size() > 0) ? good_q.pop_front() : 1'b0;
                    if (ok) begin
                        m_busy = 0; m_valid = 1; m_done = 1;
                    end else if (m_a == MAXT - 1) begin
                        m_busy = 0; m_flt = 1; m_done = 1;
                    end else begin
                        m_a++; m_c = 0;
                    end
                end else begin
                    m_c++;
                end
            end else if (start_i) begin
                m_busy = 1; m_c = 0; m_a = 0; m_valid = 0; m_flt = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    int rd0_cnt = 0, blen_cnt = 0, shd_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_rd, exp_we;
            exp_rd = m_busy && (m_c <= N);
            exp_we = m_busy && (m_c >= LAT) && (m_c - LAT < N);
            check(busy_o == m_busy, "R2 busy", busy_o, m_busy);
            check(mem_rd_o == exp_rd, "R2 mem_rd", mem_rd_o, exp_rd);
            if (exp_rd) check(int'(mem_addr_o) == m_c, "R2 mem_addr", mem_addr_o, m_c);
            check(shd_we_o == exp_we, "R3 shd_we", shd_we_o, exp_we);
            if (exp_we) begin
                check(int'(shd_addr_o) == m_c - LAT, "R3 shd_addr", shd_addr_o, m_c - LAT);
                check(shd_data_o == mem_arr[m_c - LAT], "R3 shd_data", shd_data_o, mem_arr[m_c - LAT]);
            end
            check(done_o == m_done, "R5 done", done_o, m_done);
            check(cfg_valid_o == m_valid, "R5 cfg_valid", cfg_valid_o, m_valid);
            check({flt_global_o, flt_group_o, flt_crc_o} == {3{m_flt}}, "R7 flags",
                  {flt_global_o, flt_group_o, flt_crc_o}, {3{m_flt}});
            if (busy_o) blen_cnt++;
            if (shd_we_o) shd_cnt++;
            if (mem_rd_o && mem_addr_o == '0) rd0_cnt++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 50000);
            finish_run();
        end
    end

    task automatic run_seq(input int bad, input bit poke, output int tries, output int blen);
        rd0_cnt = 0; blen_cnt = 0; shd_cnt = 0;
        bad_left = bad;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        // R9: first busy cycle shows valid and flags cleared
        check(busy_o && !cfg_valid_o && !flt_crc_o && !flt_global_o && !flt_group_o,
              "R9 clear on start", {busy_o, cfg_valid_o, flt_crc_o}, 3'b100);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            repeat (12) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        tries = rd0_cnt;
        blen = blen_cnt;
        bad_left = 0;
    endtask

    initial begin
        int t, b;
        for (int i = 0; i < N; i++) mem_arr[i] = 8'(i * 17 + 3);
        mem_arr[N] = ref_crc();

        repeat (3) @(negedge clk);
        check({mem_rd_o, shd_we_o, busy_o, done_o, cfg_valid_o, flt_crc_o} == 6'b0,
              "R1 in reset", {mem_rd_o, shd_we_o, busy_o, done_o, cfg_valid_o, flt_crc_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_rd_o, shd_we_o, busy_o, done_o, cfg_valid_o, flt_global_o, flt_group_o, flt_crc_o} == 8'b0,
              "R1 after reset", busy_o, 0);

        // Clean pass on first attempt
        run_seq(0, 0, t, b);
        check(t == 1, "R5 attempts on pass", t, 1);
        check(b == L, "R5 busy length", b, L);
        check(cfg_valid_o && !flt_crc_o, "R4 good CRC accepted", cfg_valid_o, 1);

        // Three failures then pass
        run_seq(3, 0, t, b);
        check(t == 4, "R6 retry count", t, 4);
        check(b == 4 * L, "R6 attempt length", b, 4 * L);
        check(shd_cnt == 4 * N, "R3 writes every attempt", shd_cnt, 4 * N);
        check(cfg_valid_o, "R6 pass after retries", cfg_valid_o, 1);

        // Every attempt fails
        run_seq(100, 0, t, b);
        check(t == MAXT, "R7 attempts exhausted", t, MAXT);
        check(b == WORST, "R10 worst-case length", b, WORST);
        check(flt_global_o && flt_group_o && flt_crc_o && !cfg_valid_o, "R7 fault flags",
              {flt_global_o, flt_group_o, flt_crc_o, cfg_valid_o}, 4'b1110);

        // Recovery after failure
        run_seq(0, 0, t, b);
        check(cfg_valid_o && !flt_crc_o, "R9 recovery pass", cfg_valid_o, 1);

        // Starts while busy are ignored
        run_seq(2, 1, t, b);
        check(t == 3, "R8 attempts unchanged", t, 3);
        check(b == 3 * L, "R8 length unchanged", b, 3 * L);
        @(negedge clk);
        check(!busy_o, "R8 no extra sequence", busy_o, 0);

        // Pass on the last attempt, then full budget again
        run_seq(7, 0, t, b);
        check(t == MAXT && cfg_valid_o, "R11 pass on last attempt", t, MAXT);
        run_seq(100, 0, t, b);
        check(t == MAXT && flt_crc_o, "R11 full attempts after pass", t, MAXT);

        // Data corrupted with stale CRC word
        mem_arr[3] = mem_arr[3] ^ 8'h40;
        run_seq(0, 0, t, b);
        check(t == MAXT && flt_crc_o && !cfg_valid_o, "R4 data error detected", t, MAXT);

        // Other patterns with matching CRC
        for (int i = 0; i < N; i++) mem_arr[i] = 8'hA5 ^ 8'(i * 29);
        mem_arr[N] = ref_crc();
        run_seq(0, 0, t, b);
        check(t == 1 && cfg_valid_o, "R4 second pattern", t, 1);
        for (int i = 0; i < N; i++) mem_arr[i] = 8'h00;
        mem_arr[N] = ref_crc();
        run_seq(0, 0, t, b);
        check(t == 1 && cfg_valid_o, "R4 all-zero pattern", t, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule